// File: doc/BRIEF.md
# Voltage Window Supervisor

This block watches a supply through two clocked comparator flags, one for under-voltage and one for over-voltage. It also takes a push-button style manual reset and a periodic heartbeat from a processor. From these it makes three level outputs.

The first output is a deglitched window-OK flag. The second is a power-good that gates the next rail in a start-up chain. The third is a system reset, held for a programmable time after the last cause goes away. The filter for leaving the window and the filter for entering it have separate, software-set limits. The leaving filter is normally the longer one, so that short dips are absorbed while recovery stays fast.

Power-good follows the window alone. Reset combines the window, a watchdog timeout and the debounced manual reset. Each of reset and power-good has its own polarity select. At power-on, reset is asserted and power-good is not good. Both stay that way until the window has been valid for the hold time.

Top module: `window_supervisor`

## Requirements
- R1: `win_ok_o` is 1 only when `uv_i`=0 and `ov_i`=0 have both been sampled for the filter limit. Leaving the window (either flag 1) clears `win_ok_o` after the fall limit in consecutive samples.
- R2: An out-of-window excursion shorter than `cfg_fall_i` consecutive samples leaves `win_ok_o`, `pg_o` and `rst_o` unchanged. Any return to the current filtered state restarts the count.
- R3: Entering the window needs `cfg_rise_i` consecutive in-window samples, and leaving it needs `cfg_fall_i` samples. A limit of 0 acts as 1. `win_ok_o` changes on the edge that takes the last needed sample.
- R4: Reset asserts on the edge after any cause is seen. The causes are window lost, watchdog timeout and debounced manual reset. Reset releases on the `cfg_hold_i`-th edge with no cause present. A cause arriving during the hold restarts it.
- R5: With `cfg_wd_i`=W>0 and no heartbeat rising edge, the watchdog times out W edges after reset releases. Reset asserts on the following edge.
- R6: The watchdog count is held at zero while reset is asserted, and a rising edge on `wdi_i` also clears it.
- R7: `cfg_wd_i`=0 disables the watchdog, so a missing heartbeat never causes reset.
- R8: `mr_i` (active high) passes `SYNC_STAGES` flops and then needs `MR_DB` consecutive equal samples to change. A shorter pulse has no effect on `rst_o`.
- R9: Power-good depends on the window only. It turns good `cfg_hold_i` edges after `win_ok_o` rises and goes not-good one edge after `win_ok_o` falls. Manual reset and watchdog do not affect it.
- R10: `cfg_rst_hi_i`=1 makes `rst_o` high when reset is asserted, and 0 makes it low. `cfg_pg_hi_i`=1 makes `pg_o` high when good, and 0 makes it low.
- R11: During and after `rst_ni`, `win_ok_o`=0, reset is asserted and power-good is not good, until the window has held for the hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_i | input | 1 | Under-voltage comparator flag, 1 = below lower threshold |
| ov_i | input | 1 | Over-voltage comparator flag, 1 = above upper threshold |
| mr_i | input | 1 | Manual reset request, active high, asynchronous |
| wdi_i | input | 1 | Watchdog heartbeat, asynchronous |
| cfg_rise_i | input | FILT_W | Samples needed to enter the window |
| cfg_fall_i | input | FILT_W | Samples needed to leave the window |
| cfg_hold_i | input | HOLD_W | Reset and power-good hold cycles |
| cfg_wd_i | input | WD_W | Watchdog timeout in cycles, 0 = off |
| cfg_rst_hi_i | input | 1 | Reset output polarity, 1 = active high |
| cfg_pg_hi_i | input | 1 | Power-good polarity, 1 = active high |
| win_ok_o | output | 1 | Filtered window-OK |
| pg_o | output | 1 | Power-good |
| rst_o | output | 1 | System reset |

## Verification
A comparator change first sampled on edge e moves `win_ok_o` on edge e+limit-1. Reset and power-good then assert one edge later. Reset releases `cfg_hold_i` edges after the last cause clears, and `mr_i` adds `SYNC_STAGES` edges before debouncing starts. The watchdog fires W edges after release. For every stimulus the driver computes these cycle numbers from the configured limits and queues the expected output levels. A monitor compares them on the falling edge of the matching cycle, including the cycle just before each change, so both early and late transitions are caught.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int unsigned DEF_FILT_W = 8;
  localparam int unsigned DEF_HOLD_W = 16;
  localparam int unsigned DEF_WD_W   = 16;
  localparam int unsigned DEF_MR_DB  = 4;
  localparam int unsigned DEF_SYNC   = 2;

  typedef struct packed {
    logic win_lost;
    logic wd_to;
    logic mr;
  } rst_cause_t;
endpackage

// File: rtl/ws_sync.sv
module ws_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff_q <= '0;
      end else begin
        ff_q[0] <= d_i;
        for (int i = 1; i < int'(STAGES); i++) ff_q[i] <= ff_q[i-1];
      end
    end
    assign q_o = ff_q[STAGES-1];
  end
endmodule

// File: rtl/ws_deglitch.sv
module ws_deglitch #(
  parameter int unsigned W       = 8,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         raw_i,
  input  logic [W-1:0] lim_rise_i,
  input  logic [W-1:0] lim_fall_i,
  output logic         filt_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim;
  logic [W:0]   nxt;

  // limit for leaving the current filtered state
  assign lim = filt_o ? lim_fall_i : lim_rise_i;
  assign nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_o <= RST_VAL;
    end else if (raw_i == filt_o) begin
      cnt_q <= '0;
    end else if (nxt >= {1'b0, lim}) begin
      filt_o <= raw_i;
      cnt_q  <= '0;
    end else begin
      cnt_q <= nxt[W-1:0];
    end
  end

  p_commit_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_o != $past(filt_o)) |-> ($past(raw_i) == filt_o));
  p_agree_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == filt_o) |=> $stable(filt_o));
endmodule

// File: rtl/ws_hold.sv
module ws_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cause_i,
  input  logic [W-1:0] hold_i,
  output logic         act_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  assign nxt = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b1;
      cnt_q <= '0;
    end else if (cause_i) begin
      act_o <= 1'b1;
      cnt_q <= '0;
    end else if (act_o) begin
      if (nxt >= {1'b0, hold_i}) begin
        act_o <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= nxt[W-1:0];
      end
    end
  end

  p_cause_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i |=> act_o);
  p_release_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_o) |-> !$past(cause_i));
endmodule

// File: rtl/ws_watchdog.sv
module ws_watchdog #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hb_i,
  input  logic [W-1:0] lim_i,
  input  logic         rst_act_i,
  output logic         to_o
);
  logic         hb_q;
  logic         en;
  logic         hb_rise;
  logic [W-1:0] cnt_q;

  assign en      = |lim_i;
  assign hb_rise = hb_i & ~hb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      hb_q <= hb_i;
      if (rst_act_i || hb_rise || !en) cnt_q <= '0;
      else if (cnt_q < lim_i)          cnt_q <= cnt_q + 1'b1;
    end
  end

  assign to_o = en && (cnt_q >= lim_i);

  p_quiet_in_reset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_act_i) |-> !to_o);
  p_off_when_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_i == '0) |-> !to_o);
endmodule

// File: rtl/window_supervisor.sv
module window_supervisor
  import ws_pkg::*;
#(
  parameter int unsigned FILT_W      = DEF_FILT_W,
  parameter int unsigned HOLD_W      = DEF_HOLD_W,
  parameter int unsigned WD_W        = DEF_WD_W,
  parameter int unsigned MR_DB       = DEF_MR_DB,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uv_i,
  input  logic              ov_i,
  input  logic              mr_i,
  input  logic              wdi_i,
  input  logic [FILT_W-1:0] cfg_rise_i,
  input  logic [FILT_W-1:0] cfg_fall_i,
  input  logic [HOLD_W-1:0] cfg_hold_i,
  input  logic [WD_W-1:0]   cfg_wd_i,
  input  logic              cfg_rst_hi_i,
  input  logic              cfg_pg_hi_i,
  output logic              win_ok_o,
  output logic              pg_o,
  output logic              rst_o
);
  localparam int unsigned MR_W = (MR_DB < 2) ? 1 : $clog2(MR_DB + 1);
  localparam logic [MR_W-1:0] MR_LIM = MR_W'(MR_DB);

  logic       raw_ok;
  logic       win_ok;
  logic       mr_s, wdi_s, mr_db;
  logic       wd_to;
  logic       rst_act, pg_act, pg_good;
  rst_cause_t cause;

  assign raw_ok = ~uv_i & ~ov_i;

  ws_deglitch #(.W(FILT_W), .RST_VAL(1'b0)) u_win_flt (
    .clk_i, .rst_ni, .raw_i(raw_ok),
    .lim_rise_i(cfg_rise_i), .lim_fall_i(cfg_fall_i), .filt_o(win_ok));

  ws_sync #(.STAGES(SYNC_STAGES)) u_mr_sync  (.clk_i, .rst_ni, .d_i(mr_i),  .q_o(mr_s));
  ws_sync #(.STAGES(SYNC_STAGES)) u_wdi_sync (.clk_i, .rst_ni, .d_i(wdi_i), .q_o(wdi_s));

  ws_deglitch #(.W(MR_W), .RST_VAL(1'b0)) u_mr_flt (
    .clk_i, .rst_ni, .raw_i(mr_s),
    .lim_rise_i(MR_LIM), .lim_fall_i(MR_LIM), .filt_o(mr_db));

  ws_watchdog #(.W(WD_W)) u_wd (
    .clk_i, .rst_ni, .hb_i(wdi_s), .lim_i(cfg_wd_i),
    .rst_act_i(rst_act), .to_o(wd_to));

  always_comb begin
    cause.win_lost = ~win_ok;
    cause.wd_to    = wd_to;
    cause.mr       = mr_db;
  end

  ws_hold #(.W(HOLD_W)) u_rst_hold (
    .clk_i, .rst_ni, .cause_i(|cause), .hold_i(cfg_hold_i), .act_o(rst_act));

  // power-good sees only the window
  ws_hold #(.W(HOLD_W)) u_pg_hold (
    .clk_i, .rst_ni, .cause_i(cause.win_lost), .hold_i(cfg_hold_i), .act_o(pg_act));

  assign pg_good  = ~pg_act;
  assign win_ok_o = win_ok;
  assign rst_o    = cfg_rst_hi_i ? rst_act : ~rst_act;
  assign pg_o     = cfg_pg_hi_i  ? pg_good : ~pg_good;

  p_win_from_raw_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_ok && !$past(win_ok)) |-> $past(raw_ok));
  p_pg_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(win_ok) |=> !pg_good);
  p_mr_resets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_db |=> rst_act);
  p_pg_under_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_good |-> (win_ok || $past(win_ok)));
endmodule

// File: tb/sim_window_supervisor.sv
module sim_window_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int RISE = 3;
  localparam int FALL = 6;
  localparam int HOLD = 8;
  localparam int WD   = 20;
  localparam int MRD  = 4;
  localparam int SYN  = 2;

  typedef struct {
    int    cyc;
    bit    w;
    bit    r;
    bit    p;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 1'b0, ov = 1'b0, mr = 1'b0, wdi = 1'b0;
  logic [7:0]  cfg_rise = 8'(RISE);
  logic [7:0]  cfg_fall = 8'(FALL);
  logic [15:0] cfg_hold = 16'(HOLD);
  logic [15:0] cfg_wd   = 16'(WD);
  logic rpol = 1'b0, ppol = 1'b1;
  logic win_ok, pg, rst;
  bit   hb_en = 1'b1;
  int   hb_cnt = 0;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  exp_t q[$];

  window_supervisor #(.FILT_W(8), .HOLD_W(16), .WD_W(16), .MR_DB(MRD), .SYNC_STAGES(SYN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .uv_i(uv), .ov_i(ov), .mr_i(mr), .wdi_i(wdi),
    .cfg_rise_i(cfg_rise), .cfg_fall_i(cfg_fall), .cfg_hold_i(cfg_hold), .cfg_wd_i(cfg_wd),
    .cfg_rst_hi_i(rpol), .cfg_pg_hi_i(ppol),
    .win_ok_o(win_ok), .pg_o(pg), .rst_o(rst));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (hb_en) begin
      hb_cnt++;
      wdi = hb_cnt[2];
    end else begin
      wdi = 1'b0;
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b cyc=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic push(int at, bit w, bit r, bit p, string req);
    exp_t e;
    e.cyc = at; e.w = w; e.r = r; e.p = p; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compare queued expectations on the falling edge
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      if (e.cyc < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s missed slot actual=%0d expected=%0d", e.req, cyc, e.cyc);
      end else begin
        chk(e.req, win_ok, e.w, "win_ok");
        chk(e.req, rst, rpol ? e.r : !e.r, "rst");
        chk(e.req, pg, ppol ? e.p : !e.p, "pg");
      end
    end
  end

  task automatic tick(int k);
    repeat (k) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    tick(1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL run timeout actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n, m, m2, r;
    // R11 cold start
    repeat (3) @(negedge clk);
    chk("R11", win_ok, 1'b0, "win_ok in reset");
    chk("R11", rst, 1'b0, "rst in reset");
    chk("R11", pg, 1'b0, "pg in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    n = cyc;
    push(n+RISE-1, 0, 1, 0, "R11");
    push(n+RISE,   1, 1, 0, "R3");
    push(n+RISE+HOLD-1, 1, 1, 0, "R11");
    push(n+RISE+HOLD,   1, 0, 1, "R11");
    drain();

    // R2 short dip
    n = cyc;
    for (int k = 1; k <= FALL+3; k++) push(n+k, 1, 0, 1, "R2");
    uv = 1'b1; tick(FALL-1); uv = 1'b0;
    drain();

    // R2 bounce restarts count
    n = cyc;
    for (int k = 1; k <= 14; k++) push(n+k, 1, 0, 1, "R2");
    ov = 1'b1; tick(FALL-2); ov = 1'b0; tick(1); ov = 1'b1; tick(FALL-2); ov = 1'b0;
    drain();

    // R1 R3 R4 R9 long under-voltage
    n = cyc;
    push(n+FALL-1, 1, 0, 1, "R3");
    push(n+FALL,   0, 0, 1, "R1");
    push(n+FALL+1, 0, 1, 0, "R9");
    uv = 1'b1; tick(10); m = cyc; uv = 1'b0;
    push(m+RISE-1, 0, 1, 0, "R3");
    push(m+RISE,   1, 1, 0, "R3");
    push(m+RISE+HOLD-1, 1, 1, 0, "R4");
    push(m+RISE+HOLD,   1, 0, 1, "R4");
    drain();

    // R1 long over-voltage
    n = cyc;
    push(n+FALL-1, 1, 0, 1, "R1");
    push(n+FALL,   0, 0, 1, "R1");
    push(n+FALL+1, 0, 1, 0, "R1");
    ov = 1'b1; tick(12); m = cyc; ov = 1'b0;
    push(m+RISE+HOLD-1, 1, 1, 0, "R1");
    push(m+RISE+HOLD,   1, 0, 1, "R1");
    drain();

    // R8 R9 long manual reset
    n = cyc;
    push(n+SYN+MRD,   1, 0, 1, "R8");
    push(n+SYN+MRD+1, 1, 1, 1, "R8");
    mr = 1'b1; tick(8); m = cyc; mr = 1'b0;
    push(m+SYN+MRD+HOLD-1, 1, 1, 1, "R9");
    push(m+SYN+MRD+HOLD,   1, 0, 1, "R4");
    drain();

    // R8 short manual pulse ignored
    n = cyc;
    for (int k = 1; k <= SYN+MRD+HOLD; k++) push(n+k, 1, 0, 1, "R8");
    mr = 1'b1; tick(MRD-1); mr = 1'b0;
    drain();

    // R4 retrigger during hold
    mr = 1'b1; tick(8); m = cyc; mr = 1'b0;
    tick(5); mr = 1'b1;
    tick(8); m2 = cyc; mr = 1'b0;
    push(m2+SYN+MRD+HOLD-1, 1, 1, 1, "R4");
    push(m2+SYN+MRD+HOLD,   1, 0, 1, "R4");
    chk("R4", rst, 1'b0, "held at first release slot");
    if (m+SYN+MRD+HOLD != cyc) chk("R4", 1'b1, 1'b1, "slot");
    drain();

    // R5 R6 watchdog: cleared while in reset, fires WD after release
    hb_en = 1'b0;
    n = cyc;
    push(n+FALL+1, 0, 1, 0, "R6");
    uv = 1'b1; tick(40); m = cyc; uv = 1'b0;
    r = m + RISE + HOLD;
    push(r-1, 1, 1, 0, "R6");
    push(r,   1, 0, 1, "R6");
    push(r+WD,   1, 0, 1, "R5");
    push(r+WD+1, 1, 1, 1, "R5");
    drain();
    hb_en = 1'b1;
    tick(3*(WD+HOLD));
    @(negedge clk);
    chk("R6", rst, 1'b1, "heartbeat restores");
    chk("R5", pg, 1'b1, "pg unaffected");
    tick(1);

    // R7 watchdog disabled
    cfg_wd = '0; hb_en = 1'b0;
    n = cyc;
    for (int k = 1; k <= 3*WD; k++) push(n+k, 1, 0, 1, "R7");
    drain();
    cfg_wd = 16'(WD); hb_en = 1'b1;
    tick(2);

    // R10 polarity swap
    rpol = 1'b1; ppol = 1'b0;
    n = cyc;
    push(n, 1, 0, 1, "R10");
    push(n+FALL+1, 0, 1, 0, "R10");
    uv = 1'b1; tick(10); m = cyc; uv = 1'b0;
    push(m+RISE+HOLD, 1, 0, 1, "R10");
    drain();
    @(negedge clk);
    chk("R10", rst, 1'b0, "active-high rst idle");
    chk("R10", pg, 1'b0, "active-low pg good");

    finish_run();
  end
endmodule